// File: doc/BRIEF.md
# Multi-lane jitter test pattern generator

This block produces a repeating four-lane test frame, one byte per lane per clock, for stressing receivers and measuring jitter on a four-lane 10G attachment link. Each frame is a two-row preamble, then a disparity-control row, then a run-length coded core sequence, then a fixed check row, and then a programmable number of idle rows. The core sequence drives one lane pair from low to high transition density while the other pair goes from high to low. Because of this, the two pairs never run in step.

The core sequence is held as a compact table of 27 entries. Each entry is a four-byte row and a repeat count, and together they expand to 188 rows. A mode input picks one of two variants. The half-length variant plays the core once. The full-length variant plays it twice back to back. Each variant has its own control row and its own check row. The half-length variant relies on an odd number of idle rows so that lane disparity alternates from one frame to the next. A status output flags an even gap setting.

The output word carries lane 0 in bits 7:0 and lane 3 in bits 31:24. A per-lane control flag marks control characters. A start strobe marks the control row of every frame. The enable input freezes the generator in place.

Top module: `jtp_gen`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, the outputs show preamble row 0: data_o = 32'h555555FB, ctrl_o = 4'b0001, sof_o = 0.
- R2: A frame is, in order: preamble row 0, then preamble row 1 (32'hD5555555, ctrl_o = 0), then the control row, then the core sequence, then the check row, then the gap rows. After the last gap row, the next frame starts at preamble row 0.
- R3: Lane i is data_o[8*i+7:8*i]. In a written row "A B C D", A is lane 3 and D is lane 0.
- R4: The core sequence is 188 rows, in this order:
  - 40 rows of 7E B5 7E B5;
  - 8 rows alternating 7E EB 7E EB and 7E F4 7E F4, starting with EB;
  - 84 rows of 7E 7E 7E 7E;
  - 8 rows alternating F4 7E F4 7E and EB 7E EB 7E, starting with F4, where the eighth row is AB 7E AB 7E;
  - 40 rows of B5 7E B5 7E;
  - 8 rows alternating EB F4 EB F4 and F4 EB F4 EB, starting with EB F4, where the eighth row is F4 AB F4 AB.
- R5: Half-length mode (half_mode_i = 1): the control row is 55 55 13 07, the core plays once, and the check row is E6 42 BC 62.
- R6: Full-length mode (half_mode_i = 0): the control row is D5 55 07 07, the core plays twice back to back, and the check row is F7 C6 DB D2.
- R7: The number of gap rows equals gap_rows_i as sampled on the clock that leaves the check row, and 0 means no gap rows. Each gap row is 07 on all lanes with ctrl_o = 4'b1111.
- R8: ctrl_o is 0 on the control row, on every core row, on the check row and on preamble row 1.
- R9: With en_i low at a clock edge, every output and the internal position stay unchanged.
- R10: sof_o is 1 exactly while the control row is shown and 0 at all other times.
- R11: gap_even_o is 1 when gap_rows_i is even (0 counts as even) and 0 when it is odd. It follows the input combinationally.
- R12: half_mode_i is sampled only on the enabled clock that leaves preamble row 1. Changes to it at any other time have no effect on the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Advance one row per clock when high |
| half_mode_i | input | 1 | 1 selects the half-length variant, 0 the full-length variant |
| gap_rows_i | input | GAP_W | Number of idle rows after each frame |
| data_o | output | 32 | Row word; lane i in bits 8*i+7:8*i |
| ctrl_o | output | 4 | Per-lane control-character flag |
| sof_o | output | 1 | High on the control row of each frame |
| gap_even_o | output | 1 | Gap setting is even |

## Verification
A bad row pointer or repeat counter shows up as a wrong byte in the cycle the row is due. The shift then persists until the end of the frame, so a single miscount is caught within one row. A mode bit latched at the wrong moment shows up at the control row, or at the latest 188 rows later, when the check row or the second core pass appears too early or too late. A gap counter that is off by one moves the next frame's preamble by one cycle, which the per-cycle comparison catches on the first row after the gap.

// File: rtl/jtp_pkg.sv
package jtp_pkg;
  localparam int LANES        = 4;
  localparam int BYTE_W       = 8;
  localparam int WORD_W       = LANES * BYTE_W;
  localparam int CORE_ENTRIES = 27;
  localparam int PTR_W        = $clog2(CORE_ENTRIES);
  localparam int REP_W        = 8;

  typedef enum logic [2:0] {
    PH_PRE  = 3'd0,
    PH_CTRL = 3'd1,
    PH_CORE = 3'd2,
    PH_CRC  = 3'd3,
    PH_GAP  = 3'd4
  } phase_e;

  typedef struct packed {
    logic [WORD_W-1:0] word;
    logic [REP_W-1:0]  reps;
  } core_row_t;

  localparam logic [WORD_W-1:0] W_PRE0      = 32'h555555FB;
  localparam logic [LANES-1:0]  C_PRE0      = 4'b0001;
  localparam logic [WORD_W-1:0] W_PRE1      = 32'hD5555555;
  localparam logic [WORD_W-1:0] W_IDLE      = 32'h07070707;
  localparam logic [WORD_W-1:0] W_CTRL_HALF = 32'h55551307;
  localparam logic [WORD_W-1:0] W_CTRL_FULL = 32'hD5550707;
  localparam logic [WORD_W-1:0] W_CRC_HALF  = 32'hE642BC62;
  localparam logic [WORD_W-1:0] W_CRC_FULL  = 32'hF7C6DBD2;

  // run-length core table; three long runs each followed by eight single rows
  function automatic core_row_t core_row(input int idx);
    core_row_t r;
    int k;
    r.reps = REP_W'(1);
    r.word = '0;
    if (idx == 0) begin
      r.word = 32'h7EB57EB5; r.reps = REP_W'(40);
    end else if (idx < 9) begin
      k = idx - 1;
      r.word = (k % 2 == 0) ? 32'h7EEB7EEB : 32'h7EF47EF4;
    end else if (idx == 9) begin
      r.word = 32'h7E7E7E7E; r.reps = REP_W'(84);
    end else if (idx < 18) begin
      k = idx - 10;
      if (k == 7)          r.word = 32'hAB7EAB7E;
      else if (k % 2 == 0) r.word = 32'hF47EF47E;
      else                 r.word = 32'hEB7EEB7E;
    end else if (idx == 18) begin
      r.word = 32'hB57EB57E; r.reps = REP_W'(40);
    end else if (idx < CORE_ENTRIES) begin
      k = idx - 19;
      if (k == 7)          r.word = 32'hF4ABF4AB;
      else if (k % 2 == 0) r.word = 32'hEBF4EBF4;
      else                 r.word = 32'hF4EBF4EB;
    end
    return r;
  endfunction
endpackage

// File: rtl/jtp_core_rom.sv
module jtp_core_rom
  import jtp_pkg::*;
#(
  parameter int ENTRIES = CORE_ENTRIES,
  parameter int AW      = PTR_W
) (
  input  logic [AW-1:0]     cur_ptr_i,
  input  logic [AW-1:0]     nxt_ptr_i,
  output logic [WORD_W-1:0] cur_word_o,
  output logic [REP_W-1:0]  cur_reps_o,
  output logic [REP_W-1:0]  nxt_reps_o
);
  core_row_t tbl [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_tbl
    localparam core_row_t ENT = core_row(g);
    assign tbl[g] = ENT;
  end

  always_comb begin
    cur_word_o = '0;
    cur_reps_o = '0;
    nxt_reps_o = '0;
    if (int'(cur_ptr_i) < ENTRIES) begin
      cur_word_o = tbl[cur_ptr_i].word;
      cur_reps_o = tbl[cur_ptr_i].reps;
    end
    if (int'(nxt_ptr_i) < ENTRIES) nxt_reps_o = tbl[nxt_ptr_i].reps;
  end
endmodule

// File: rtl/jtp_seq.sv
module jtp_seq
  import jtp_pkg::*;
#(
  parameter int GAP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             half_mode_i,
  input  logic [GAP_W-1:0] gap_rows_i,
  input  logic [REP_W-1:0] cur_reps_i,
  input  logic [REP_W-1:0] nxt_reps_i,
  output phase_e           phase_o,
  output logic             pre_idx_o,
  output logic             mode_o,
  output logic [PTR_W-1:0] row_ptr_o,
  output logic [PTR_W-1:0] nxt_ptr_o
);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(CORE_ENTRIES - 1);

  phase_e           phase_q;
  logic             pre_idx_q, mode_q, pass_q;
  logic [PTR_W-1:0] row_ptr_q;
  logic [REP_W-1:0] rep_cnt_q;
  logic [GAP_W-1:0] gap_cnt_q;

  assign nxt_ptr_o = (phase_q == PH_CORE && row_ptr_q != LAST_PTR) ? row_ptr_q + 1'b1 : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_PRE;
      pre_idx_q <= 1'b0;
      mode_q    <= 1'b0;
      pass_q    <= 1'b0;
      row_ptr_q <= '0;
      rep_cnt_q <= '0;
      gap_cnt_q <= '0;
    end else if (en_i) begin
      unique case (phase_q)
        PH_PRE: begin
          pre_idx_q <= ~pre_idx_q;
          if (pre_idx_q) begin
            phase_q <= PH_CTRL;
            mode_q  <= half_mode_i;
          end
        end
        PH_CTRL: begin
          phase_q   <= PH_CORE;
          row_ptr_q <= '0;
          pass_q    <= 1'b0;
          rep_cnt_q <= nxt_reps_i - 1'b1;
        end
        PH_CORE: begin
          if (rep_cnt_q != '0) begin
            rep_cnt_q <= rep_cnt_q - 1'b1;
          end else if (row_ptr_q != LAST_PTR) begin
            row_ptr_q <= nxt_ptr_o;
            rep_cnt_q <= nxt_reps_i - 1'b1;
          end else if (!mode_q && !pass_q) begin
            pass_q    <= 1'b1;
            row_ptr_q <= '0;
            rep_cnt_q <= nxt_reps_i - 1'b1;
          end else begin
            phase_q <= PH_CRC;
            pass_q  <= 1'b0;
          end
        end
        PH_CRC: begin
          if (gap_rows_i == '0) begin
            phase_q   <= PH_PRE;
            pre_idx_q <= 1'b0;
          end else begin
            phase_q   <= PH_GAP;
            gap_cnt_q <= gap_rows_i - 1'b1;
          end
        end
        PH_GAP: begin
          if (gap_cnt_q == '0) begin
            phase_q   <= PH_PRE;
            pre_idx_q <= 1'b0;
          end else begin
            gap_cnt_q <= gap_cnt_q - 1'b1;
          end
        end
        default: phase_q <= PH_PRE;
      endcase
    end
  end

  assign phase_o   = phase_q;
  assign pre_idx_o = pre_idx_q;
  assign mode_o    = mode_q;
  assign row_ptr_o = row_ptr_q;

  // repeat counter must stay below the active row's length
  assert_rep_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_CORE |-> rep_cnt_q < cur_reps_i);

  // second preamble row hands over to the control row
  assert_pre_to_ctrl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_PRE && pre_idx_q && en_i) |=> phase_q == PH_CTRL);

  // mode is frozen outside the preamble hand-over
  assert_mode_stable_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_PRE) |=> $stable(mode_q));
endmodule

// File: rtl/jtp_row_mux.sv
module jtp_row_mux
  import jtp_pkg::*;
(
  input  phase_e            phase_i,
  input  logic              pre_idx_i,
  input  logic              mode_i,
  input  logic [WORD_W-1:0] core_word_i,
  output logic [WORD_W-1:0] data_o,
  output logic [LANES-1:0]  ctrl_o,
  output logic              sof_o
);
  logic [LANES-1:0] is_idle;

  // per-lane control flag: idle rows flag every lane
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign is_idle[l] = (phase_i == PH_GAP) || (l == 0 && phase_i == PH_PRE && !pre_idx_i);
  end

  always_comb begin
    sof_o  = 1'b0;
    ctrl_o = is_idle;
    unique case (phase_i)
      PH_PRE:  data_o = pre_idx_i ? W_PRE1 : W_PRE0;
      PH_CTRL: begin
        data_o = mode_i ? W_CTRL_HALF : W_CTRL_FULL;
        sof_o  = 1'b1;
      end
      PH_CORE: data_o = core_word_i;
      PH_CRC:  data_o = mode_i ? W_CRC_HALF : W_CRC_FULL;
      PH_GAP:  data_o = W_IDLE;
      default: data_o = W_IDLE;
    endcase
  end
endmodule

// File: rtl/jtp_gen.sv
module jtp_gen
  import jtp_pkg::*;
#(
  parameter int GAP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             half_mode_i,
  input  logic [GAP_W-1:0] gap_rows_i,
  output logic [31:0]      data_o,
  output logic [3:0]       ctrl_o,
  output logic             sof_o,
  output logic             gap_even_o
);
  phase_e            phase;
  logic              pre_idx, mode;
  logic [PTR_W-1:0]  row_ptr, nxt_ptr;
  logic [WORD_W-1:0] core_word;
  logic [REP_W-1:0]  cur_reps, nxt_reps;

  jtp_core_rom u_rom (
    .cur_ptr_i  (row_ptr),
    .nxt_ptr_i  (nxt_ptr),
    .cur_word_o (core_word),
    .cur_reps_o (cur_reps),
    .nxt_reps_o (nxt_reps)
  );

  jtp_seq #(.GAP_W(GAP_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .half_mode_i (half_mode_i),
    .gap_rows_i  (gap_rows_i),
    .cur_reps_i  (cur_reps),
    .nxt_reps_i  (nxt_reps),
    .phase_o     (phase),
    .pre_idx_o   (pre_idx),
    .mode_o      (mode),
    .row_ptr_o   (row_ptr),
    .nxt_ptr_o   (nxt_ptr)
  );

  jtp_row_mux u_mux (
    .phase_i     (phase),
    .pre_idx_i   (pre_idx),
    .mode_i      (mode),
    .core_word_i (core_word),
    .data_o      (data_o),
    .ctrl_o      (ctrl_o),
    .sof_o       (sof_o)
  );

  assign gap_even_o = ~gap_rows_i[0];

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(data_o) && $stable(ctrl_o) && $stable(sof_o)));

  assert_sof_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_o && en_i) |=> !sof_o);

  assert_gap_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase == PH_GAP |-> (data_o == 32'h07070707 && ctrl_o == 4'b1111));

  assert_data_flags_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_CTRL || phase == PH_CORE || phase == PH_CRC) |-> ctrl_o == 4'b0000);
endmodule

// File: tb/jtp_gen_tb_top.sv
module jtp_gen_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        half_mode_i = 1'b0;
  logic [7:0]  gap_rows_i = 8'd3;
  logic [31:0] data_o;
  logic [3:0]  ctrl_o;
  logic        sof_o, gap_even_o;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk_i = ~clk_i;

  jtp_gen dut_i (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s cyc=%0d act=%h exp=%h", req, what, cyc, act, exp);
    end
  endtask

  function automatic logic [31:0] core_exp(input int c);
    int k;
    if (c < 40) return 32'h7EB57EB5;
    if (c < 48) begin k = c - 40; return (k % 2 == 0) ? 32'h7EEB7EEB : 32'h7EF47EF4; end
    if (c < 132) return 32'h7E7E7E7E;
    if (c < 140) begin
      k = c - 132;
      if (k == 7) return 32'hAB7EAB7E;
      return (k % 2 == 0) ? 32'hF47EF47E : 32'hEB7EEB7E;
    end
    if (c < 180) return 32'hB57EB57E;
    k = c - 180;
    if (k == 7) return 32'hF4ABF4AB;
    return (k % 2 == 0) ? 32'hEBF4EBF4 : 32'hF4EBF4EB;
  endfunction

  // model state
  int mpos, mgap;
  bit mhalf;

  function automatic int crc_pos(input bit h);
    return 3 + 188 * (h ? 1 : 2);
  endfunction

  task automatic check_row(input string tag_in, input bit held);
    logic [31:0] ed;
    logic [3:0]  ec;
    logic        es;
    string       t;
    int          cp;
    cp = crc_pos(mhalf);
    es = 1'b0; ec = 4'b0000;
    if (mpos == 0)      begin ed = 32'h555555FB; ec = 4'b0001; t = "R2"; end
    else if (mpos == 1) begin ed = 32'hD5555555; t = "R2"; end
    else if (mpos == 2) begin ed = mhalf ? 32'h55551307 : 32'hD5550707; es = 1'b1; t = mhalf ? "R5" : "R6"; end
    else if (mpos < cp) begin ed = core_exp((mpos - 3) % 188); t = "R4"; end
    else if (mpos == cp) begin ed = mhalf ? 32'hE642BC62 : 32'hF7C6DBD2; t = mhalf ? "R5" : "R6"; end
    else begin ed = 32'h07070707; ec = 4'b1111; t = "R7"; end
    if (tag_in != "") t = tag_in;
    if (held) t = "R9";
    chk(t, "data", data_o, ed);
    chk((mpos >= 1 && mpos <= cp) ? "R8" : t, "ctrl", {28'd0, ctrl_o}, {28'd0, ec});
    chk("R10", "sof", {31'd0, sof_o}, {31'd0, es});
    if (mpos == 3 && !held) begin
      chk("R3", "lane0", {24'd0, data_o[7:0]}, 32'hB5);
      chk("R3", "lane3", {24'd0, data_o[31:24]}, 32'h7E);
    end
  endtask

  task automatic model_step(input bit h_in, input int g_in);
    int cp;
    cp = crc_pos(mhalf);
    if (mpos == 1) begin mhalf = h_in; mpos = 2; end
    else if (mpos == cp) begin mgap = g_in; mpos = (g_in == 0) ? 0 : mpos + 1; end
    else if (mpos > cp && mpos == cp + mgap) mpos = 0;
    else mpos++;
  endtask

  // mode: 0 steady, 1 periodic enable drops, 2 inputs toggle every cycle
  task automatic run_cfg(input bit h, input int g, input int frames, input int kind);
    int done;
    bit en_prev;
    string tag;
    tag = (kind == 2) ? "R12" : "";
    @(negedge clk_i);
    rst_ni = 1'b0; en_i = 1'b1; half_mode_i = h; gap_rows_i = 8'(g);
    @(posedge clk_i); @(negedge clk_i);
    chk("R1", "rst_data", data_o, 32'h555555FB);
    chk("R1", "rst_ctrl", {28'd0, ctrl_o}, 32'h1);
    chk("R1", "rst_sof", {31'd0, sof_o}, 32'h0);
    rst_ni = 1'b1;
    mpos = 0; mgap = 0; mhalf = 1'b0;
    done = 0; en_prev = 1'b1;
    while (done < frames) begin
      check_row(tag, !en_prev);
      if (kind == 1) en_i = (cyc % 5 != 3);
      else en_i = 1'b1;
      if (kind == 2) begin
        half_mode_i = cyc[0];
        gap_rows_i  = 8'(cyc % 4);
      end
      #1;
      chk("R11", "gap_even", {31'd0, gap_even_o}, {31'd0, ~gap_rows_i[0]});
      en_prev = en_i;
      @(posedge clk_i);
      cyc++;
      if (en_i) begin
        model_step(half_mode_i, int'(gap_rows_i));
        if (mpos == 0) done++;
      end
      @(negedge clk_i);
    end
  endtask

  initial begin
    for (int m = 0; m < 2; m++) begin
      for (int gi = 0; gi < 5; gi++) begin
        int g;
        g = (gi == 4) ? 5 : gi;
        run_cfg(m[0], g, 2, 0);
      end
    end
    run_cfg(1'b1, 3, 2, 1);
    run_cfg(1'b0, 2, 1, 1);
    run_cfg(1'b0, 0, 5, 2);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog cyc=%0d act=hung exp=done", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule